// File: doc/BRIEF.md
# Stereo Panning Audio Mixer

This block turns two one-bit sound channels into a pair of left and right sample words. Each channel carries a pulse level from its tone generator, a small volume code and an eight-bit pan setting. A sixteen-entry level table, held in registers, maps a volume code to an amplitude. A channel whose pulse is high uses the entry picked by its volume code. A channel whose pulse is low uses entry zero. The chosen amplitude is then divided between the two sides in proportion to the pan setting, and each side adds up the shares of both channels.

All settings are written through one register port. The port covers the table entries, the two volume codes and the two pan registers. The two pan registers come out of reset centred, so software that never writes them hears both channels in the middle of the stereo image. New output words are taken on a sample strobe and held until the next one. The division by the full pan scale is done with a reciprocal multiply and a rounding offset, so the block contains no divider.

Top module: `stereo_pan_mixer`

## Requirements
- R1: After reset both outputs read 0, both volume codes are 0, both pan registers hold 128, and table entry i holds i*65535/15 (4369*i).
- R2: A channel's level is table entry [volume code] while its pulse input is high, and table entry 0 while it is low.
- R3: For level v and pan p, the right share is v*p/255 and the left share is v*(255-p)/255, each rounded to the nearest integer (the quotient never falls exactly on a half).
- R4: Pan 0 gives the whole level to the left side and nothing to the right. Pan 255 gives the whole level to the right side and nothing to the left.
- R5: Register map on `reg_addr`: 0 to 15 write table entry n with all 16 data bits; 16 + c writes the volume code of channel c from data bits [3:0]; 24 + c writes the pan of channel c from data bits [7:0].
- R6: A write to any other address (18 to 23, 26 to 31) changes no setting.
- R7: Each output is the sum of both channels' shares for that side, clamped to 65535.
- R8: The outputs change only at a clock edge where `sample_strobe` is high, and show the new value after that edge. Without the strobe they hold.
- R9: When a register write and the strobe occur at the same edge, the sample is formed from the settings held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address |
| reg_data | input | 16 | Register write data |
| pulse | input | 2 | Pulse level of each channel, bit c for channel c |
| sample_strobe | input | 1 | Take a new output sample at this edge |
| audio_left | output | 16 | Left sample |
| audio_right | output | 16 | Right sample |

## Verification
The bench builds the block with its default parameters: two channels, 4-bit volume codes, 8-bit pan and 16-bit levels. Because table entries and outputs share the 16-bit width, two channels panned to the same side at top level overflow the sum, which exercises the clamp. The 8-bit pan lets both extremes and odd values such as 1 and 254 be driven directly. Odd pan values are where the rounding of the reciprocal multiply is most likely to go wrong.

// File: rtl/pan_mix_pkg.sv
package pan_mix_pkg;

    // Register map bases; the table occupies TAB_BASE .. TAB_BASE + 2**VOL_W - 1
    localparam int unsigned TAB_BASE = 0;
    localparam int unsigned VOL_BASE = 16;
    localparam int unsigned PAN_BASE = 24;

    // Rounded scaling of lvl by w / (2**pan_w - 1) via reciprocal multiply
    function automatic longint unsigned recip_const(input int lvl_w, input int pan_w);
        longint unsigned pmax;
        pmax = (longint'(1) << pan_w) - 1;
        return ((longint'(1) << (lvl_w + 2 * pan_w)) + pmax - 1) / pmax;
    endfunction

endpackage

// File: rtl/pan_mix_regs.sv
module pan_mix_regs #(
    parameter int NCH    = 2,
    parameter int VOL_W  = 4,
    parameter int PAN_W  = 8,
    parameter int LVL_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [LVL_W-1:0]                 wr_data,
    output logic [(1<<VOL_W)-1:0][LVL_W-1:0] tab_o,
    output logic [NCH-1:0][VOL_W-1:0]        vol_o,
    output logic [NCH-1:0][PAN_W-1:0]        pan_o
);
    import pan_mix_pkg::*;

    localparam int NTAB = 1 << VOL_W;

    typedef struct packed {
        logic [NTAB-1:0][LVL_W-1:0] tab;
        logic [NCH-1:0][VOL_W-1:0]  vol;
        logic [NCH-1:0][PAN_W-1:0]  pan;
    } regs_t;

    function automatic regs_t init_regs();
        regs_t r;
        r = '0;
        for (int i = 0; i < NTAB; i++) begin
            r.tab[i] = LVL_W'((longint'(i) * ((longint'(1) << LVL_W) - 1)) / longint'(NTAB - 1));
        end
        for (int c = 0; c < NCH; c++) begin
            r.pan[c] = PAN_W'(1 << (PAN_W - 1));
        end
        return r;
    endfunction

    localparam regs_t RST_VAL = init_regs();

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int i = 0; i < NTAB; i++) begin
                if (wr_addr == ADDR_W'(TAB_BASE + i)) regs_d.tab[i] = wr_data;
            end
            for (int c = 0; c < NCH; c++) begin
                if (wr_addr == ADDR_W'(VOL_BASE + c)) regs_d.vol[c] = wr_data[VOL_W-1:0];
                if (wr_addr == ADDR_W'(PAN_BASE + c)) regs_d.pan[c] = wr_data[PAN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_VAL;
        else        regs_q <= regs_d;
    end

    assign tab_o = regs_q.tab;
    assign vol_o = regs_q.vol;
    assign pan_o = regs_q.pan;

    // R5: a pan write to channel 0 lands in that channel's pan register
    a_r5_pan_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(PAN_BASE)) |=> (pan_o[0] == $past(wr_data[PAN_W-1:0])));

    // R6: without a write every setting keeps its value
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(tab_o) && $stable(vol_o) && $stable(pan_o)));

endmodule

// File: rtl/pan_mix_split.sv
module pan_mix_split #(
    parameter int VOL_W = 4,
    parameter int PAN_W = 8,
    parameter int LVL_W = 16
) (
    input  logic                             pulse,
    input  logic [VOL_W-1:0]                 vol,
    input  logic [PAN_W-1:0]                 pan,
    input  logic [(1<<VOL_W)-1:0][LVL_W-1:0] tab,
    output logic [LVL_W-1:0]                 level_o,
    output logic [LVL_W-1:0]                 left_o,
    output logic [LVL_W-1:0]                 right_o
);
    import pan_mix_pkg::*;

    localparam int PMAX  = (1 << PAN_W) - 1;
    localparam int HALF  = PMAX / 2;
    localparam int SHIFT = LVL_W + 2 * PAN_W;
    localparam int Y_W   = LVL_W + PAN_W;
    localparam int P_W   = LVL_W + SHIFT + 2;
    localparam longint unsigned RECIP = recip_const(LVL_W, PAN_W);

    // round(lvl * w / PMAX): floor((lvl*w + HALF) * RECIP / 2**SHIFT)
    function automatic logic [LVL_W-1:0] scale(input logic [LVL_W-1:0] lvl,
                                               input logic [PAN_W-1:0] w);
        logic [Y_W-1:0] y;
        logic [P_W-1:0] p;
        y = Y_W'(lvl) * Y_W'(w) + Y_W'(HALF);
        p = P_W'(y) * P_W'(RECIP);
        return LVL_W'(p >> SHIFT);
    endfunction

    logic [PAN_W-1:0] pan_inv;

    always_comb begin
        level_o = pulse ? tab[vol] : tab[0];
        pan_inv = PAN_W'(PMAX) - pan;
        right_o = scale(level_o, pan);
        left_o  = scale(level_o, pan_inv);
    end

endmodule

// File: rtl/stereo_pan_mixer.sv
module stereo_pan_mixer #(
    parameter int NCH    = 2,
    parameter int VOL_W  = 4,
    parameter int PAN_W  = 8,
    parameter int LVL_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LVL_W-1:0]  reg_data,
    input  logic [NCH-1:0]    pulse,
    input  logic              sample_strobe,
    output logic [LVL_W-1:0]  audio_left,
    output logic [LVL_W-1:0]  audio_right
);
    localparam int NTAB  = 1 << VOL_W;
    localparam int SUM_W = LVL_W + $clog2(NCH) + 1;
    localparam logic [SUM_W-1:0] FULL = SUM_W'((longint'(1) << LVL_W) - 1);

    typedef struct packed {
        logic [LVL_W-1:0] left;
        logic [LVL_W-1:0] right;
    } out_t;

    logic [NTAB-1:0][LVL_W-1:0] tab;
    logic [NCH-1:0][VOL_W-1:0]  vol;
    logic [NCH-1:0][PAN_W-1:0]  pan;
    logic [NCH-1:0][LVL_W-1:0]  level, share_l, share_r;
    logic [SUM_W-1:0]           sum_l, sum_r;
    out_t                       out_d, out_q;

    pan_mix_regs #(
        .NCH(NCH), .VOL_W(VOL_W), .PAN_W(PAN_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_data), .tab_o(tab), .vol_o(vol), .pan_o(pan)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pan_mix_split #(
            .VOL_W(VOL_W), .PAN_W(PAN_W), .LVL_W(LVL_W)
        ) u_split (
            .pulse(pulse[c]), .vol(vol[c]), .pan(pan[c]), .tab(tab),
            .level_o(level[c]), .left_o(share_l[c]), .right_o(share_r[c])
        );

        // R3: the two shares of a channel add back to its level
        a_r3_share_sum: assert property (@(posedge clk) disable iff (!rst_n)
            (SUM_W'(share_l[c]) + SUM_W'(share_r[c])) == SUM_W'(level[c]));

        // R2: a channel with its pulse low plays table entry 0
        a_r2_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
            !pulse[c] |-> (level[c] == tab[0]));

        // R4: full-left pan gives no right share
        a_r4_full_left: assert property (@(posedge clk) disable iff (!rst_n)
            (pan[c] == '0) |-> (share_r[c] == '0));
    end

    always_comb begin
        sum_l = '0;
        sum_r = '0;
        for (int c = 0; c < NCH; c++) begin
            sum_l = sum_l + SUM_W'(share_l[c]);
            sum_r = sum_r + SUM_W'(share_r[c]);
        end
        out_d = out_q;
        if (sample_strobe) begin
            out_d.left  = (sum_l > FULL) ? LVL_W'(FULL) : LVL_W'(sum_l);
            out_d.right = (sum_r > FULL) ? LVL_W'(FULL) : LVL_W'(sum_r);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign audio_left  = out_q.left;
    assign audio_right = out_q.right;

    // R8: outputs hold between strobes
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |=> ($stable(audio_left) && $stable(audio_right)));

    // R7: a sample never falls below any single contributing share
    a_r7_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> (audio_left >= $past(share_l[0]) && audio_right >= $past(share_r[0])));

endmodule

// File: tb/stereo_pan_mixer_test.sv
module stereo_pan_mixer_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0] v0;
        logic [3:0] v1;
        logic [7:0] p0;
        logic [7:0] p1;
        logic [1:0] pl;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{4'd15, 4'd0,  8'd0,   8'd0,   2'b01},
        '{4'd15, 4'd15, 8'd0,   8'd0,   2'b11},
        '{4'd15, 4'd15, 8'd255, 8'd255, 2'b11},
        '{4'd7,  4'd9,  8'd64,  8'd200, 2'b11},
        '{4'd7,  4'd9,  8'd64,  8'd200, 2'b01},
        '{4'd7,  4'd9,  8'd64,  8'd200, 2'b00},
        '{4'd3,  4'd12, 8'd1,   8'd254, 2'b10},
        '{4'd15, 4'd15, 8'd0,   8'd255, 2'b11},
        '{4'd1,  4'd2,  8'd100, 8'd37,  2'b11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_data = '0;
    logic [1:0]  pulse = '0;
    logic        sample_strobe = 1'b0;
    logic [15:0] audio_left, audio_right;

    int checks = 0;
    int errors = 0;

    // bench copy of the settings, kept from the register map
    int m_tab [16];
    int m_vol [2];
    int m_pan [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    stereo_pan_mixer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_data(reg_data), .pulse(pulse), .sample_strobe(sample_strobe),
        .audio_left(audio_left), .audio_right(audio_right)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd_share(input int lvl, input int w);
        return (2 * lvl * w + 255) / 510;
    endfunction

    function automatic int level_of(input int c, input logic p);
        return p ? m_tab[m_vol[c]] : m_tab[0];
    endfunction

    function automatic int side(input logic [1:0] pl, input bit right);
        int s = 0;
        for (int c = 0; c < 2; c++) begin
            s += rnd_share(level_of(c, pl[c]), right ? m_pan[c] : 255 - m_pan[c]);
        end
        return (s > 65535) ? 65535 : s;
    endfunction

    function automatic void model_write(input int a, input int d);
        if (a < 16) m_tab[a] = d;
        else if (a == 16 || a == 17) m_vol[a - 16] = d & 15;
        else if (a == 24 || a == 25) m_pan[a - 24] = d & 255;
    endfunction

    task automatic reg_write(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = 5'(a);
        reg_data = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic strobe();
        @(negedge clk);
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int el, er, hl, hr;
        for (int i = 0; i < 16; i++) m_tab[i] = 4369 * i;
        m_vol = '{0, 0};
        m_pan = '{128, 128};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: outputs cleared after reset
        check("R1 left after reset", int'(audio_left), 0);
        check("R1 right after reset", int'(audio_right), 0);

        // R1: centred pan from reset, channel 0 at top level
        reg_write(16, 15);
        pulse = 2'b01;
        strobe();
        check("R1 centre pan left", int'(audio_left), 32639);
        check("R1 centre pan right", int'(audio_right), 32896);

        // R8: no strobe, outputs hold while inputs change
        pulse = 2'b00;
        reg_write(24, 0);
        repeat (3) @(negedge clk);
        check("R8 hold left", int'(audio_left), 32639);
        check("R8 hold right", int'(audio_right), 32896);

        // vector table: R2/R3/R4/R7 under varied settings
        for (int v = 0; v < NVEC; v++) begin
            reg_write(16, int'(VEC[v].v0));
            reg_write(17, int'(VEC[v].v1));
            reg_write(24, int'(VEC[v].p0));
            reg_write(25, int'(VEC[v].p1));
            pulse = VEC[v].pl;
            strobe();
            check($sformatf("R2/R3/R4/R7 vector %0d left", v), int'(audio_left), side(pulse, 1'b0));
            check($sformatf("R2/R3/R4/R7 vector %0d right", v), int'(audio_right), side(pulse, 1'b1));
        end

        // R7: saturation spot values
        reg_write(16, 15); reg_write(17, 15);
        reg_write(24, 0);  reg_write(25, 0);
        pulse = 2'b11;
        strobe();
        check("R7 clamp left", int'(audio_left), 65535);
        check("R4 full left gives zero right", int'(audio_right), 0);

        // R6: writes to unmapped addresses change nothing
        reg_write(20, 16'hFFFF);
        reg_write(31, 16'h00AA);
        reg_write(18, 16'h0003);
        reg_write(26, 16'h0080);
        reg_write(0, 0);
        reg_write(17, 0);
        pulse = 2'b01;
        strobe();
        check("R6 unmapped write left", int'(audio_left), 65535);
        check("R6 unmapped write right", int'(audio_right), 0);

        // R2/R5: table entry 0 is heard when the pulse is low
        reg_write(0, 1000);
        reg_write(24, 255);
        reg_write(25, 0);
        pulse = 2'b00;
        strobe();
        check("R2 low pulse right", int'(audio_right), 1000);
        check("R2 low pulse left", int'(audio_left), 1000);

        // R5: a rewritten table entry is used
        reg_write(16, 5);
        reg_write(5, 12345);
        pulse = 2'b01;
        strobe();
        check("R5 table write right", int'(audio_right), 12345);

        // R9: write and strobe on the same edge use the old settings
        el = side(pulse, 1'b0);
        er = side(pulse, 1'b1);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = 5'd24;
        reg_data = 16'd0;
        sample_strobe = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        sample_strobe = 1'b0;
        model_write(24, 0);
        check("R9 same edge left", int'(audio_left), el);
        check("R9 same edge right", int'(audio_right), er);
        hl = side(pulse, 1'b0);
        hr = side(pulse, 1'b1);
        strobe();
        check("R9 next strobe left", int'(audio_left), hl);
        check("R9 next strobe right", int'(audio_right), hr);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule